// File: doc/BRIEF.md
# Reset Cause and Soft Reset Control Register

This block is one 32-bit memory-mapped register in a host bridge that holds the cause of the most recent system reset. Software can read it, acknowledge recorded causes, and ask for a soft reset of either the power-on kind or the externally-initiated kind. A request produces a one-clock pulse on `soft_rst_req`. The system reset sequencer turns that pulse into a real reset and reports each applied reset back on `sys_rst_evt`.

A saturating counter of applied resets decides whether a reset counts as a power-on reset. When the counter is zero, a reset event overwrites the whole register with only the power-on cause set. Any later reset leaves the register as it is. A soft power-on request clears the counter, so the reset it triggers is again recorded as a power-on reset.

The register occupies an 8-byte window starting at `BASE_ADDR`. Only the upper word, with address bit 2 set, is implemented. Register bits: 31 power-on, 30 soft power-on, 29 soft external, 28 button power-on, 27 button external. Bits 26:0 do not exist.

Top module: `rstctl_csr`

## Requirements
- R1: While `rst` is high and after it is released, the register reads 0x00000000, `soft_rst_req` is low, and the reset counter is zero.
- R2: Write data bits 26:0 are discarded. Read data bits 26:0 are always zero.
- R3: Writing a one to bit 31, 28 or 27 clears that bit. Writing a zero to it leaves it unchanged.
- R4: Writing a one to bit 30 or 29 sets that bit. Writing a zero leaves it unchanged. No write can clear these bits.
- R5: Reads of the lower word (address bit 2 clear) and of any address outside the window return zero. Writes to those addresses change nothing and raise no request.
- R6: A reset event while the counter is zero loads the register with exactly 0x80000000. A reset event while the counter is non-zero leaves the register unchanged.
- R7: A write with bit 30 set raises `soft_rst_req` for exactly one clock, on the cycle after the write. It also clears the counter, so the next reset event performs the R6 load.
- R8: A write with bit 29 set and bit 30 clear raises the same one-clock request and leaves the counter unchanged. A write with both bits clear raises no request.
- R9: The counter stops at its maximum value (2^CNT_W - 1) and does not wrap. Any number of reset events without a soft power-on request never repeats the R6 load.
- R10: If a write and a reset event occur in the same cycle, the write is ignored completely: the register is not updated by it, no request is raised, and the counter is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sys_rst_evt | input | 1 | One-cycle marker that a system reset was applied |
| soft_rst_req | output | 1 | One-cycle soft reset request pulse |

## Verification
The assertions assume `sys_rst_evt` and `bus_wr` are single-cycle strobes sampled on the clock edge, and that `bus_addr` and `bus_wdata` are stable when the strobe is high. The stimulus changes every input at the falling edge and holds it for a full cycle, so each write and each event is seen exactly once. It sweeps all 32 combinations of the five live bits, each with non-zero junk in the low bits, and follows every write with a reset event, so the counter state is exercised from both zero and non-zero. A separate run of 40 back-to-back events drives the counter well past its saturation point.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned REG_W = 32;

    localparam int unsigned BIT_POR      = 31;
    localparam int unsigned BIT_SOFT_POR = 30;
    localparam int unsigned BIT_SOFT_XIR = 29;

    localparam logic [REG_W-1:0] LIVE_MASK = 32'hF800_0000;
    localparam logic [REG_W-1:0] W1C_MASK  = 32'h9800_0000;
    localparam logic [REG_W-1:0] W1S_MASK  = 32'h6000_0000;
    localparam logic [REG_W-1:0] POR_VALUE = 32'h8000_0000;

    typedef struct packed {
        logic             upd;
        logic [REG_W-1:0] clr_bits;
        logic [REG_W-1:0] set_bits;
        logic             soft_por;
        logic             soft_xir;
    } wr_cmd_t;

    function automatic logic [REG_W-1:0] apply_write(input logic [REG_W-1:0] cur,
                                                     input wr_cmd_t c);
        return (cur & ~c.clr_bits) | c.set_bits;
    endfunction

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              sys_rst_evt,
    output wr_cmd_t           cmd,
    output logic              rd_sel
);
    logic             win_hit;
    logic             wr_hit;
    logic [REG_W-1:0] kept;
    logic             unused_addr_lsb;

    assign unused_addr_lsb = ^bus_addr[1:0];

    assign win_hit = (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
    assign rd_sel  = win_hit & bus_addr[2];
    assign wr_hit  = bus_wr & rd_sel & ~sys_rst_evt;
    assign kept    = bus_wdata & LIVE_MASK;

    always_comb begin
        cmd          = '0;
        cmd.upd      = wr_hit;
        if (wr_hit) begin
            cmd.clr_bits = kept & W1C_MASK;
            cmd.set_bits = kept & W1S_MASK;
            cmd.soft_por = kept[BIT_SOFT_POR];
            cmd.soft_xir = ~kept[BIT_SOFT_POR] & kept[BIT_SOFT_XIR];
        end
    end

endmodule

// File: rtl/rstctl_porcnt.sv
module rstctl_porcnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_rst_evt,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             first_rst
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign first_rst = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (sys_rst_evt) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/rstctl_status.sv
module rstctl_status
    import rstctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_rst_evt,
    input  logic             first_rst,
    input  wr_cmd_t          cmd,
    input  logic             rd_sel,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] bus_rdata,
    output logic             soft_rst_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (sys_rst_evt) begin
            if (first_rst) begin
                status_q <= POR_VALUE;
            end
        end else if (cmd.upd) begin
            status_q <= apply_write(status_q, cmd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_rst_req <= 1'b0;
        end else begin
            soft_rst_req <= cmd.soft_por | cmd.soft_xir;
        end
    end

    assign bus_rdata = rd_sel ? status_q : '0;

endmodule

// File: rtl/rstctl_csr.sv
module rstctl_csr
    import rstctl_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int unsigned       CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sys_rst_evt,
    output logic              soft_rst_req
);
    wr_cmd_t          cmd;
    logic             rd_sel;
    logic             first_rst;
    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] status_q;

    rstctl_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .sys_rst_evt(sys_rst_evt),
        .cmd        (cmd),
        .rd_sel     (rd_sel)
    );

    rstctl_porcnt #(
        .CNT_W(CNT_W)
    ) u_porcnt (
        .clk        (clk),
        .rst        (rst),
        .sys_rst_evt(sys_rst_evt),
        .cnt_clr    (cmd.soft_por),
        .cnt_q      (cnt_q),
        .first_rst  (first_rst)
    );

    rstctl_status u_status (
        .clk         (clk),
        .rst         (rst),
        .sys_rst_evt (sys_rst_evt),
        .first_rst   (first_rst),
        .cmd         (cmd),
        .rd_sel      (rd_sel),
        .status_q    (status_q),
        .bus_rdata   (bus_rdata),
        .soft_rst_req(soft_rst_req)
    );

endmodule

// File: rtl/rstctl_csr_chk.sv
module rstctl_csr_chk #(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int unsigned       CNT_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              sys_rst_evt,
    input logic              soft_rst_req,
    input logic [31:0]       status_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cnt_clr
);
    logic upper_hit;
    logic unused_chk;

    assign upper_hit  = (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]) && bus_addr[2];
    assign unused_chk = ^{bus_addr[1:0], bus_wdata[31], bus_wdata[28:0]};

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[26:0] == 27'd0);

    assert_outside_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !upper_hit |-> bus_rdata == 32'd0);

    assert_soft_por_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        status_q[30] && !sys_rst_evt |=> status_q[30]);

    assert_soft_xir_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        status_q[29] && !sys_rst_evt |=> status_q[29]);

    assert_first_load_R6: assert property (@(posedge clk) disable iff (rst)
        sys_rst_evt && cnt_q == '0 |=> status_q == 32'h8000_0000);

    assert_req_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        soft_rst_req |-> $past(bus_wr && upper_hit && !sys_rst_evt &&
                               (bus_wdata[30] || bus_wdata[29])));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q != '0 && !cnt_clr |=> cnt_q != '0);

    assert_evt_blocks_req_R10: assert property (@(posedge clk) disable iff (rst)
        sys_rst_evt |=> !soft_rst_req);

endmodule

bind rstctl_csr rstctl_csr_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_rst_evt (sys_rst_evt),
    .soft_rst_req(soft_rst_req),
    .status_q    (status_q),
    .cnt_q       (cnt_q),
    .cnt_clr     (cmd.soft_por)
);

// File: tb/rstctl_csr_tb.sv
`timescale 1ns/1ps
module rstctl_csr_tb;
    localparam int unsigned CNT_W   = 4;
    localparam int          CNT_MAX = (1 << CNT_W) - 1;
    localparam logic [15:0] A_HI    = 16'hF024;
    localparam logic [15:0] A_LO    = 16'hF020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = A_HI;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_evt = 1'b0;
    logic        soft_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_stat = '0;
    int          m_cnt  = 0;

    always #2.5 clk = ~clk;

    rstctl_csr #(.ADDR_W(16), .BASE_ADDR(16'hF020), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_evt(sys_rst_evt), .soft_rst_req(soft_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_evt();
        if (m_cnt == 0) m_stat = 32'h8000_0000;
        if (m_cnt < CNT_MAX) m_cnt++;
    endtask

    // returns the expected request
    function automatic logic model_wr(input logic [31:0] d);
        logic [31:0] k;
        k = d & 32'hF800_0000;
        m_stat = (m_stat & ~(k & 32'h9800_0000)) | (k & 32'h6000_0000);
        if (k[30]) m_cnt = 0;
        return k[30] | k[29];
    endfunction

    task automatic check_stat(input string tag);
        bus_addr = A_HI;
        #1;
        chk(tag, bus_rdata, m_stat);
    endtask

    task automatic do_evt(input string tag);
        @(negedge clk);
        sys_rst_evt = 1'b1;
        @(negedge clk);
        sys_rst_evt = 1'b0;
        model_evt();
        check_stat(tag);
    endtask

    // write to upper word with full field checks
    task automatic do_wr(input logic [31:0] d);
        logic exp_req;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        exp_req = model_wr(d);
        #1;
        chk("R3", bus_rdata & 32'h9800_0000, m_stat & 32'h9800_0000);
        chk("R4", bus_rdata & 32'h6000_0000, m_stat & 32'h6000_0000);
        chk("R2", bus_rdata & 32'h07FF_FFFF, 32'h0);
        chk(d[30] ? "R7" : "R8", {31'd0, soft_rst_req}, {31'd0, exp_req});
        @(negedge clk);
        #1;
        chk("R7", {31'd0, soft_rst_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", bus_rdata, 32'h0);
        chk("R1", {31'd0, soft_rst_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1", bus_rdata, 32'h0);
        chk("R1", {31'd0, soft_rst_req}, 32'h0);

        // first reset loads power-on cause, second leaves it
        do_evt("R6");
        do_evt("R6");

        // lower word and out-of-window writes ignored
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_LO; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_addr = 16'hF02C;
        #1;
        chk("R5", {31'd0, soft_rst_req}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R5", {31'd0, soft_rst_req}, 32'h0);
        check_stat("R5");
        bus_addr = A_LO; #1; chk("R5", bus_rdata, 32'h0);
        bus_addr = 16'hF000; #1; chk("R5", bus_rdata, 32'h0);
        bus_addr = 16'hE024; #1; chk("R5", bus_rdata, 32'h0);

        // sweep all live-bit combinations, each followed by a reset event
        for (int v = 0; v < 32; v++) begin
            do_wr({v[4:0], 27'h5A5_A5A5 ^ 27'(v * 7)});
            do_evt("R6");
        end

        // write coinciding with reset event is dropped
        do_wr(32'h6000_0000);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = 32'hFFFF_FFFF; sys_rst_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sys_rst_evt = 1'b0;
        model_evt();
        #1;
        chk("R10", {31'd0, soft_rst_req}, 32'h0);
        check_stat("R10");
        do_evt("R10");

        // saturation: reach counter 1 with clean register, then many events
        do_wr(32'h4000_0000);
        do_evt("R7");
        do_wr(32'h9800_0000);
        for (int i = 0; i < 40; i++) begin
            do_evt("R9");
        end
        do_wr(32'h2000_0000);
        do_evt("R8");
        do_wr(32'h4000_0000);
        do_evt("R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1: watchdog actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule